// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a display fetch engine and the colour pipeline of a display controller. It accepts 32-bit words read from a framebuffer and emits one pixel per clock. Depending on the configured depth, each pixel leaves either as a palette index, for a lookup stage downstream, or as a direct 24-bit colour. The configuration covers the depth code, two ordering controls (byte reversal and pixel reversal), a red/blue exchange bit, a 2-bit select that picks the 16-bit layout on the base variant, and a flag that marks the extended variant, which has two extra depth codes.

The block also reports how many framebuffer bytes one display line occupies, derived from the line width in pixels, so the fetch engine can size its reads. Both the word input and the pixel output use a valid/ready handshake. Configuration must be held stable while a line is in flight; it may change between lines when the block is idle.

Top module: `fb_unpack`

## Requirements
- R1: Depth codes are 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp, 5=32 bpp, 6=16 bpp 565 and 7=12 bpp (held in a 16-bit slot); a word carries 32/bpp pixel slots. For codes 0 to 3 the pixel is a palette index in the low bits of `pix_index`, zero-extended, and `pix_direct` is 0.
- R2: `line_bytes` equals width>>3 for 1 bpp, width>>2 for 2 bpp, width>>1 for 4 bpp, width for 8 bpp, width<<1 for every 16-bit-slot mode (codes 4, 6, 7) and width<<2 for 32 bpp.
- R3: With neither ordering bit set, slot k of a word is taken from bits [k*bpp +: bpp], so the first pixel comes from the least significant end.
- R4: When `be_bytes` is 1, the four bytes of the word are reversed (byte 0 swaps with byte 3, byte 1 with byte 2) before slots are taken as in R3, and `be_pixels` has no effect.
- R5: When only `be_pixels` is 1, pixels narrower than 8 bits are taken from the most significant end of each byte first, bytes still in ascending order; for 8 bpp and wider it changes nothing.
- R6: On the base variant (`ext_variant`=0), codes 4, 6 and 7 all use the 16-bit path chosen by `fmt16_sel`: 1 selects 5551 (red [4:0], green [9:5], blue [14:10], bit 15 ignored); 3 selects 565 with red and blue always exchanged; 0 and 2 select 565 (red [4:0], green [10:5], blue [15:11]) with `bgr` honoured.
- R7: On the extended variant, code 4 is 5551, code 6 is 565 and code 7 is 4:4:4 in the low 12 bits (red [3:0], green [7:4], blue [11:8]); `fmt16_sel` is ignored and `bgr` is honoured.
- R8: At 32 bpp the pixel is 8:8:8 in bits [23:0] with red in [7:0], green [15:8], blue [23:16]; bits [31:24] are ignored.
- R9: `pix_rgb` is {red, green, blue}, each component widened to 8 bits by a left shift; when `bgr` (or the forced exchange of R6) applies, the fields used for red and blue trade places.
- R10: `pix_last` is 1 on exactly the width-th pixel of each line (a width of 0 acts as 1); slots remaining in that word are dropped, and the next accepted word starts a new line.
- R11: A pixel offered with `out_ready` low stays unchanged until taken; a new word is accepted only when the buffer is empty or its final pixel is leaving in the same cycle, so a steady stream gives one pixel per clock with no gaps.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.
- R13: Direct-colour pixels carry `pix_index` = 0 and `pix_direct` = 1; palette pixels carry `pix_rgb` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bpp_code | input | 3 | Depth code (R1) |
| be_bytes | input | 1 | Reverse byte order within the word |
| be_pixels | input | 1 | Take sub-byte pixels from the top of each byte |
| bgr | input | 1 | Exchange red and blue fields |
| fmt16_sel | input | 2 | 16-bit layout select, base variant only |
| ext_variant | input | 1 | Extended variant flag |
| line_width | input | WIDTH_W | Pixels per line |
| line_bytes | output | WIDTH_W+2 | Framebuffer bytes per line |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word accepted this cycle when valid |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel offered |
| out_ready | input | 1 | Pixel taken this cycle when valid |
| pix_index | output | 8 | Palette index |
| pix_rgb | output | 24 | Direct colour {R,G,B} |
| pix_direct | output | 1 | Pixel is direct colour |
| pix_last | output | 1 | Last pixel of the line |

## Verification
The awkward case is a line whose final pixel falls in the middle of a word while the sink is stalling and the source is already offering the next line's first word: the drop of leftover slots, the refill and the stall must all line up in one cycle. The bench reaches it by choosing widths that are not multiples of the slot count (37 at 1 bpp, 13 at 4 bpp, odd widths at 16 bpp) and driving both handshakes with random gaps, while a behavioural model builds each expected pixel from the requirements and compares every transfer. A separate run with no gaps confirms the one-pixel-per-clock rate across word and line boundaries.

// File: rtl/fb_unpack.sv
module fb_unpack #(
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         bpp_code,
  input  logic               be_bytes,
  input  logic               be_pixels,
  input  logic               bgr,
  input  logic [1:0]         fmt16_sel,
  input  logic               ext_variant,
  input  logic [WIDTH_W-1:0] line_width,
  output logic [WIDTH_W+1:0] line_bytes,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         pix_index,
  output logic [23:0]        pix_rgb,
  output logic               pix_direct,
  output logic               pix_last
);

  typedef enum logic [2:0] {K_PAL, K_5551, K_565, K_444, K_888} kind_e;

  kind_e              kind;
  logic               swap_rb;
  logic [2:0]         lb;
  logic [31:0]        word_q;
  logic               full;
  logic [4:0]         lane;
  logic [WIDTH_W-1:0] cnt;

  always_comb begin
    kind    = K_PAL;
    swap_rb = bgr;
    lb      = bpp_code;
    case (bpp_code)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        kind    = K_PAL;
        swap_rb = 1'b0;
      end
      3'd5: kind = K_888;
      default: begin
        lb = 3'd4;
        if (ext_variant) begin
          if (bpp_code == 3'd4)      kind = K_5551;
          else if (bpp_code == 3'd6) kind = K_565;
          else                       kind = K_444;
        end else begin
          case (fmt16_sel)
            2'd1: kind = K_5551;
            2'd3: begin
              kind    = K_565;
              swap_rb = 1'b1;
            end
            default: kind = K_565;
          endcase
        end
      end
    endcase
  end

  always_comb begin
    case (lb)
      3'd0:    line_bytes = {2'b00, line_width} >> 3;
      3'd1:    line_bytes = {2'b00, line_width} >> 2;
      3'd2:    line_bytes = {2'b00, line_width} >> 1;
      3'd3:    line_bytes = {2'b00, line_width};
      3'd4:    line_bytes = {1'b0, line_width, 1'b0};
      default: line_bytes = {line_width, 2'b00};
    endcase
  end

  logic [5:0]  ppw;
  logic [4:0]  lane_max;
  logic [31:0] wsw;
  logic [4:0]  off;
  logic [2:0]  mir;
  logic [23:0] raw;

  assign ppw      = 6'd32 >> lb;
  assign lane_max = 5'(ppw - 6'd1);
  assign wsw      = be_bytes ? {word_q[7:0], word_q[15:8], word_q[23:16], word_q[31:24]} : word_q;
  assign mir      = (!be_bytes && be_pixels && lb < 3'd3) ? 3'(4'd8 - (4'd1 << lb)) : 3'd0;
  assign off      = (lane << lb) ^ {2'b00, mir};
  assign raw      = 24'(wsw >> off);

  logic [7:0] f_lo, f_mid, f_hi;

  always_comb begin
    case (kind)
      K_5551: begin
        f_lo = {raw[4:0], 3'b000};  f_mid = {raw[9:5], 3'b000};   f_hi = {raw[14:10], 3'b000};
      end
      K_565: begin
        f_lo = {raw[4:0], 3'b000};  f_mid = {raw[10:5], 2'b00};   f_hi = {raw[15:11], 3'b000};
      end
      K_444: begin
        f_lo = {raw[3:0], 4'h0};    f_mid = {raw[7:4], 4'h0};     f_hi = {raw[11:8], 4'h0};
      end
      K_888: begin
        f_lo = raw[7:0];            f_mid = raw[15:8];            f_hi = raw[23:16];
      end
      default: begin
        f_lo = 8'h00;               f_mid = 8'h00;                f_hi = 8'h00;
      end
    endcase
  end

  always_comb begin
    case (lb)
      3'd0:    pix_index = {7'd0, raw[0]};
      3'd1:    pix_index = {6'd0, raw[1:0]};
      3'd2:    pix_index = {4'd0, raw[3:0]};
      3'd3:    pix_index = raw[7:0];
      default: pix_index = 8'h00;
    endcase
  end

  assign pix_direct = (kind != K_PAL);
  assign pix_rgb    = swap_rb ? {f_hi, f_mid, f_lo} : {f_lo, f_mid, f_hi};

  logic [WIDTH_W:0] cnt_nx;
  logic             consume;
  logic             fire;

  assign cnt_nx    = {1'b0, cnt} + {{WIDTH_W{1'b0}}, 1'b1};
  assign pix_last  = cnt_nx >= {1'b0, line_width};
  assign consume   = pix_last || (lane == lane_max);
  assign out_valid = full;
  assign fire      = full && out_ready;
  assign in_ready  = !full || (out_ready && consume);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      lane   <= '0;
      cnt    <= '0;
      word_q <= '0;
    end else begin
      if (fire) begin
        cnt <= pix_last ? '0 : cnt_nx[WIDTH_W-1:0];
        if (consume) begin
          full <= 1'b0;
          lane <= '0;
        end else begin
          lane <= lane + 5'd1;
        end
      end
      if (in_valid && in_ready) begin
        full   <= 1'b1;
        word_q <= in_word;
        lane   <= '0;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(word_q) && $stable(lane)); // R11
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && pix_last |=> cnt == '0); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    full && line_width != '0 |-> cnt < line_width); // R10
  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> lane <= lane_max); // R1

endmodule

// File: tb/fb_unpack_tb.sv
module fb_unpack_tb;
  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    bpp_code;
  logic          be_bytes, be_pixels, bgr, ext_variant;
  logic [1:0]    fmt16_sel;
  logic [WW-1:0] line_width;
  logic [WW+1:0] line_bytes;
  logic          in_valid, in_ready;
  logic [31:0]   in_word;
  logic          out_valid, out_ready;
  logic [7:0]    pix_index;
  logic [23:0]   pix_rgb;
  logic          pix_direct, pix_last;

  always #2 clk = ~clk;

  fb_unpack #(.WIDTH_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bpp_code(bpp_code), .be_bytes(be_bytes),
    .be_pixels(be_pixels), .bgr(bgr), .fmt16_sel(fmt16_sel), .ext_variant(ext_variant),
    .line_width(line_width), .line_bytes(line_bytes), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .pix_index(pix_index), .pix_rgb(pix_rgb), .pix_direct(pix_direct), .pix_last(pix_last)
  );

  typedef struct packed {
    logic        dir;
    logic [7:0]  idx;
    logic [23:0] rgb;
    logic        last;
  } pix_t;

  int checks = 0;
  int fails  = 0;
  pix_t exp_q[$];
  logic [31:0] src_q[$];
  int lcnt = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic void decode(output int b, output int kind, output bit sw);
    sw = bgr;
    if (bpp_code <= 3) begin
      b = 1 << bpp_code; kind = 0; sw = 0;
    end else if (bpp_code == 5) begin
      b = 32; kind = 4;
    end else begin
      b = 16;
      if (ext_variant) kind = (bpp_code == 4) ? 1 : (bpp_code == 6) ? 2 : 3;
      else if (fmt16_sel == 1) kind = 1;
      else if (fmt16_sel == 3) begin kind = 2; sw = 1; end
      else kind = 2;
    end
  endfunction

  function automatic pix_t model_pix(input logic [31:0] w, input int k);
    int b, kind, pos, lo, mid, hi, red, blue;
    bit sw;
    logic [31:0] nw, raw;
    pix_t p;
    decode(b, kind, sw);
    nw = w;
    if (be_bytes) for (int j = 0; j < 4; j++) nw[8*j +: 8] = w[8*(3-j) +: 8];
    if (!be_bytes && be_pixels && b < 8)
      pos = 8 * ((k * b) / 8) + 8 - b * ((k % (8 / b)) + 1);
    else
      pos = k * b;
    raw = nw >> pos;
    p = '0;
    if (kind == 0) begin
      p.idx = 8'(raw & ((32'd1 << b) - 1));
    end else begin
      p.dir = 1'b1;
      case (kind)
        1: begin lo = (raw & 31) << 3; mid = ((raw >> 5) & 31) << 3; hi = ((raw >> 10) & 31) << 3; end
        2: begin lo = (raw & 31) << 3; mid = ((raw >> 5) & 63) << 2; hi = ((raw >> 11) & 31) << 3; end
        3: begin lo = (raw & 15) << 4; mid = ((raw >> 4) & 15) << 4; hi = ((raw >> 8) & 15) << 4; end
        default: begin lo = raw & 255; mid = (raw >> 8) & 255; hi = (raw >> 16) & 255; end
      endcase
      red  = sw ? hi : lo;
      blue = sw ? lo : hi;
      p.rgb = 24'((red << 16) | (mid << 8) | blue);
    end
    return p;
  endfunction

  task automatic model_accept(input logic [31:0] w);
    int b, kind;
    bit sw;
    pix_t p;
    decode(b, kind, sw);
    for (int k = 0; k < 32 / b; k++) begin
      p = model_pix(w, k);
      lcnt++;
      p.last = (lcnt >= line_width);
      exp_q.push_back(p);
      if (p.last) begin
        lcnt = 0;
        break;
      end
    end
  endtask

  task automatic set_cfg(input logic [2:0] code, input bit ebyte, input bit epix, input bit sw,
                         input logic [1:0] sel, input bit ext, input int width);
    int b, kind;
    bit s;
    @(negedge clk);
    bpp_code = code; be_bytes = ebyte; be_pixels = epix; bgr = sw;
    fmt16_sel = sel; ext_variant = ext; line_width = WW'(width);
    #1;
    decode(b, kind, s);
    check("R2", "line_bytes", 64'(line_bytes), 64'((width * b) / 8));
  endtask

  task automatic run_lines(input string req, input int nlines, input int stall);
    int b, kind, wpl, gaps;
    bit sw, started, hold;
    pix_t saved, got;
    decode(b, kind, sw);
    wpl = (int'(line_width) + (32 / b) - 1) / (32 / b);
    for (int i = 0; i < nlines * wpl; i++) src_q.push_back($urandom);
    gaps = 0; started = 0; hold = 0; saved = '0;
    while (src_q.size() > 0 || exp_q.size() > 0 || out_valid) begin
      @(negedge clk);
      out_ready = ($urandom % 100) >= stall;
      in_valid  = (src_q.size() > 0) && (($urandom % 100) >= stall);
      in_word   = (src_q.size() > 0) ? src_q[0] : 32'h0;
      #1;
      got = {pix_direct, pix_index, pix_rgb, pix_last};
      if (hold) check("R11", "held pixel", 64'(got), 64'(saved));
      if (out_valid && out_ready) begin
        started = 1;
        if (exp_q.size() == 0) check(req, "unexpected pixel", 64'(got), 64'h0);
        else check(req, "pixel {dir,idx,rgb,last}", 64'(got), 64'(exp_q.pop_front()));
      end else if (started && stall == 0 && exp_q.size() > 0) begin
        gaps++;
      end
      hold  = out_valid && !out_ready;
      saved = got;
      if (in_valid && in_ready) begin
        model_accept(src_q[0]);
        void'(src_q.pop_front());
      end
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    if (stall == 0) check("R11", "bubbles in steady stream", 64'(gaps), 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    bpp_code = 3'd3; be_bytes = 0; be_pixels = 0; bgr = 0; fmt16_sel = 2'd0;
    ext_variant = 0; line_width = WW'(8);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R12", "out_valid after reset", 64'(out_valid), 64'h0);
    check("R12", "in_ready after reset", 64'(in_ready), 64'h1);

    for (int c = 0; c < 6; c++) set_cfg(3'(c), 0, 0, 0, 2'd0, 0, 1000);
    set_cfg(3'd7, 0, 0, 0, 2'd0, 1, 999);

    set_cfg(3'd0, 0, 0, 0, 2'd0, 0, 37);  run_lines("R3", 3, 30);   // R1 R10 R13
    set_cfg(3'd1, 0, 1, 0, 2'd0, 0, 20);  run_lines("R5", 3, 30);
    set_cfg(3'd2, 1, 1, 0, 2'd0, 0, 13);  run_lines("R4", 3, 30);
    set_cfg(3'd3, 1, 0, 0, 2'd0, 0, 9);   run_lines("R4", 3, 30);
    set_cfg(3'd3, 0, 1, 0, 2'd0, 0, 10);  run_lines("R5", 3, 30);
    set_cfg(3'd4, 0, 0, 0, 2'd0, 0, 7);   run_lines("R6", 3, 30);
    set_cfg(3'd4, 0, 0, 1, 2'd0, 0, 7);   run_lines("R6", 2, 30);
    set_cfg(3'd4, 0, 0, 0, 2'd1, 0, 9);   run_lines("R6", 3, 30);
    set_cfg(3'd4, 0, 0, 1, 2'd2, 0, 6);   run_lines("R6", 2, 30);
    set_cfg(3'd4, 0, 0, 0, 2'd3, 0, 5);   run_lines("R6", 3, 30);
    set_cfg(3'd6, 0, 0, 0, 2'd1, 0, 5);   run_lines("R6", 2, 30);
    set_cfg(3'd7, 1, 0, 1, 2'd3, 0, 5);   run_lines("R6", 2, 30);
    set_cfg(3'd4, 0, 0, 0, 2'd3, 1, 7);   run_lines("R7", 2, 30);
    set_cfg(3'd6, 0, 0, 1, 2'd1, 1, 7);   run_lines("R7", 2, 30);
    set_cfg(3'd7, 0, 0, 0, 2'd3, 1, 11);  run_lines("R7", 2, 30);
    set_cfg(3'd7, 0, 0, 1, 2'd0, 1, 4);   run_lines("R9", 2, 30);
    set_cfg(3'd5, 0, 0, 0, 2'd0, 0, 6);   run_lines("R8", 3, 30);
    set_cfg(3'd5, 1, 0, 1, 2'd3, 0, 6);   run_lines("R9", 3, 30);
    set_cfg(3'd3, 0, 0, 0, 2'd0, 0, 1);   run_lines("R10", 4, 20);
    set_cfg(3'd0, 0, 0, 0, 2'd0, 0, 70);  run_lines("R11", 3, 0);
    set_cfg(3'd4, 0, 0, 1, 2'd2, 0, 9);   run_lines("R11", 3, 0);
    set_cfg(3'd2, 0, 1, 0, 2'd0, 0, 21);  run_lines("R10", 4, 60);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule